// File: doc/BRIEF.md
# Key-Cleared Watchdog Timer

This peripheral is a watchdog timer that sits on a 32-bit register bus with byte-lane strobes. Software sets the enable bit and picks a timeout exponent. The block then divides its clock by a fixed 32 and counts the divided ticks. If the count reaches two to the power of the exponent, the block pulses a reset request for one cycle and records why in a sticky status register. The only way to restart the count is to write a 16-bit key into the upper half-word of the control register. Any other value, and any access of a different width, leaves the count alone.

The control register has a write-one-to-set alias and a write-one-to-clear alias, so software can flip the enable bit without a read-modify-write. A windowed mode punishes a key that arrives too early: a key written before the last quarter of the period raises the reset request at once. Idle and sleep states exist only as input pins. Their level at expiry is recorded in the status register.

The register port is a valid/ready handshake. A transfer takes place on a rising edge where `bus_valid` and `bus_ready` are both high. Read data is combinational and valid in the cycle the transfer is offered. `bus_ready` drops for exactly one cycle right after the enable bit is cleared. A master must hold its request through that cycle. A request withdrawn during that cycle is never performed.

Top module: `wdog_keyclr`

## Requirements
- R1: After reset the control word and the status word read as zero, `bus_ready` is 1 and `wdt_reset_req` is 0.
- R2: The control word at byte offset 0x00 uses these bits: bit 15 is the enable, bits [12:8] are the timeout exponent PS, bits [7:6] are a clock-select field that is stored but not used, and bit 0 is the window enable. Only the lanes whose byte strobe is set are written. Unused bits and the upper half-word read as zero. Read data is valid in the cycle the transfer is offered.
- R3: A write to offset 0x08 sets the control bits where the data has a one. A write to offset 0x04 clears them. Both honour the byte strobes.
- R4: With the enable bit set by a write on edge E, and no key write afterwards, `wdt_reset_req` is high for exactly the one cycle after edge E + 32·2^PS. The pulse then repeats every 32·2^PS cycles while the enable stays set.
- R5: A write of 0x5743 to offset 0x00 with strobes 4'b1100 (data bits [31:16]) on edge K restarts the count. The next pulse follows edge K + 32·2^PS.
- R6: A different key value, or the right value written with any other strobe pattern, does not change when the next pulse comes.
- R7: While the enable bit is clear, the count is held at zero, key writes have no effect and no reset request is raised. Setting the enable bit again starts a full period.
- R8: The status word at offset 0x10 is read-only, and writes to it are ignored. An expiry sets bit 4. It also sets bit 3 if `pwr_sleep` is high and bit 2 if `pwr_idle` is high. These bits stay set until software writes ones to them at offset 0x14 (lane 0).
- R9: In window mode the window opens when the tick count is at least 3·floor(2^PS/4). A valid key written while the window is closed raises `wdt_reset_req` in the cycle after the write edge and sets status bit 4. A key written while the window is open restarts the count as in R5.
- R10: `bus_ready` is low for exactly the one cycle that follows the edge that clears the enable bit. A write offered in that cycle and then withdrawn is not performed.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bus_valid | input | 1 | Register transfer offered |
| bus_ready | output | 1 | Transfer accepted on this edge (low in the busy cycle) |
| bus_write | input | 1 | 1 = write, 0 = read |
| bus_addr | input | ADDR_W | Byte address |
| bus_be | input | 4 | Byte-lane strobes |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, combinational |
| pwr_idle | input | 1 | Idle state indication |
| pwr_sleep | input | 1 | Sleep state indication |
| wdt_reset_req | output | 1 | One-cycle reset request |

## Verification
Register effects appear on the edge that accepts the write, and read data is sampled in the same cycle it is offered. The reset request comes from a register. For a timed expiry, the bench records the edge index E of the write that enabled or restarted the count. It then checks that the request is low in the cycle before edge E + 32·2^PS, high after that edge, and low again one cycle later. It also checks that a running pulse count has not moved before then. An early windowed key raises the request right after its own write edge, and the bench samples it at that point. The busy cycle is checked at the falling edge right after the write that clears the enable.

// File: rtl/wdk_pkg.sv
package wdk_pkg;
  localparam int PS_W  = 5;
  localparam int CNT_W = 1 << PS_W;

  localparam int OFS_CTRL     = 'h00;
  localparam int OFS_CTRL_CLR = 'h04;
  localparam int OFS_CTRL_SET = 'h08;
  localparam int OFS_STAT     = 'h10;
  localparam int OFS_STAT_CLR = 'h14;

  localparam logic [15:0] RESTART_KEY = 16'h5743;
  localparam logic [15:0] CTRL_MASK   = 16'h9FC1;
  localparam logic [7:0]  STAT_MASK   = 8'h1C;

  localparam int BIT_ON  = 15;
  localparam int BIT_WIN = 0;
  localparam int CS_LSB  = 6;
  localparam int PS_LSB  = 8;

  localparam int ST_EXP = 4;
  localparam int ST_SLP = 3;
  localparam int ST_IDL = 2;

  typedef struct packed {
    logic            on;
    logic            win;
    logic [1:0]      clk_sel;
    logic [PS_W-1:0] ps;
  } ctrl_t;
endpackage

// File: rtl/wdk_regs.sv
module wdk_regs
  import wdk_pkg::*;
#(
  parameter int ADDR_W = 5
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              bus_valid,
  input  logic              bus_write,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [3:0]        bus_be,
  input  logic [31:0]       bus_wdata,
  output logic              bus_ready,
  output logic [31:0]       bus_rdata,
  input  logic              fire,
  input  logic              pwr_idle,
  input  logic              pwr_sleep,
  output ctrl_t             ctrl,
  output logic              key_hit,
  output logic [7:0]        stat
);
  logic [15:0] ctrl_q, ctrl_d;
  logic [7:0]  stat_q, stat_d;
  logic        gap_q;
  logic        wr;
  logic        sel_ctrl, sel_clr, sel_set, sel_stat, sel_sclr;
  logic [15:0] lane_m, wbits;

  assign bus_ready = ~gap_q;
  assign wr        = bus_valid & bus_ready & bus_write;

  assign sel_ctrl = (bus_addr == ADDR_W'(OFS_CTRL));
  assign sel_clr  = (bus_addr == ADDR_W'(OFS_CTRL_CLR));
  assign sel_set  = (bus_addr == ADDR_W'(OFS_CTRL_SET));
  assign sel_stat = (bus_addr == ADDR_W'(OFS_STAT));
  assign sel_sclr = (bus_addr == ADDR_W'(OFS_STAT_CLR));

  assign lane_m = {{8{bus_be[1]}}, {8{bus_be[0]}}} & CTRL_MASK;
  assign wbits  = bus_wdata[15:0] & lane_m;

  assign key_hit = wr & sel_ctrl & (bus_be == 4'b1100) &
                   (bus_wdata[31:16] == RESTART_KEY);

  always_comb begin
    ctrl_d = ctrl_q;
    if (wr) begin
      if (sel_ctrl)     ctrl_d = (ctrl_q & ~lane_m) | wbits;
      else if (sel_set) ctrl_d = ctrl_q | wbits;
      else if (sel_clr) ctrl_d = ctrl_q & ~wbits;
    end
  end

  always_comb begin
    stat_d = stat_q;
    if (wr && sel_sclr && bus_be[0])
      stat_d = stat_q & ~(bus_wdata[7:0] & STAT_MASK);
    if (fire) begin
      stat_d[ST_EXP] = 1'b1;
      if (pwr_sleep) stat_d[ST_SLP] = 1'b1;
      if (pwr_idle)  stat_d[ST_IDL] = 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      ctrl_q <= '0;
      stat_q <= '0;
      gap_q  <= 1'b0;
    end else begin
      ctrl_q <= ctrl_d;
      stat_q <= stat_d;
      gap_q  <= ctrl_q[BIT_ON] & ~ctrl_d[BIT_ON];
    end
  end

  always_comb begin
    bus_rdata = '0;
    if (sel_ctrl || sel_clr || sel_set) bus_rdata = {16'h0, ctrl_q};
    else if (sel_stat || sel_sclr)      bus_rdata = {24'h0, stat_q};
  end

  assign ctrl.on      = ctrl_q[BIT_ON];
  assign ctrl.win     = ctrl_q[BIT_WIN];
  assign ctrl.clk_sel = ctrl_q[CS_LSB+1:CS_LSB];
  assign ctrl.ps      = ctrl_q[PS_LSB+PS_W-1:PS_LSB];
  assign stat         = stat_q;
endmodule

// File: rtl/wdk_timebase.sv
module wdk_timebase
  import wdk_pkg::*;
#(
  parameter int PRE_DIV = 32
) (
  input  logic             clk,
  input  logic             rst_n,
  input  ctrl_t            ctrl,
  input  logic             key_hit,
  output logic             fire,
  output logic             rst_req,
  output logic [CNT_W-1:0] count
);
  localparam int PRE_W = (PRE_DIV > 1) ? $clog2(PRE_DIV) : 1;
  localparam bit PRE_POW2 = (PRE_DIV == (1 << PRE_W));

  logic [PRE_W-1:0] pre_q;
  logic [CNT_W-1:0] cnt_q;
  logic [CNT_W-1:0] term, quarter, open_lo;
  logic             tick, at_term, early, restart;

  generate
    if (PRE_POW2) begin : g_pow2
      assign tick = &pre_q;
    end else begin : g_any
      assign tick = (pre_q == PRE_W'(PRE_DIV - 1));
    end
  endgenerate

  assign term    = CNT_W'(1) << ctrl.ps;
  assign quarter = term >> 2;
  assign open_lo = quarter + (quarter << 1);
  assign at_term = (cnt_q == term - CNT_W'(1));
  assign early   = (cnt_q < open_lo);

  assign fire    = ctrl.on & ((tick & at_term) | (key_hit & ctrl.win & early));
  assign restart = ~ctrl.on | key_hit | fire;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      pre_q   <= '0;
      cnt_q   <= '0;
      rst_req <= 1'b0;
    end else begin
      rst_req <= fire;
      if (restart) begin
        pre_q <= '0;
        cnt_q <= '0;
      end else if (tick) begin
        pre_q <= '0;
        cnt_q <= cnt_q + CNT_W'(1);
      end else begin
        pre_q <= pre_q + PRE_W'(1);
      end
    end
  end

  assign count = cnt_q;
endmodule

// File: rtl/wdog_keyclr.sv
module wdog_keyclr
  import wdk_pkg::*;
#(
  parameter int ADDR_W  = 5,
  parameter int PRE_DIV = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              bus_valid,
  output logic              bus_ready,
  input  logic              bus_write,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [3:0]        bus_be,
  input  logic [31:0]       bus_wdata,
  output logic [31:0]       bus_rdata,
  input  logic              pwr_idle,
  input  logic              pwr_sleep,
  output logic              wdt_reset_req
);
  ctrl_t            ctrl;
  logic             key_hit, fire;
  logic [7:0]       stat;
  logic [CNT_W-1:0] tb_count;
  logic             ctrl_on;

  assign ctrl_on = ctrl.on;

  wdk_regs #(.ADDR_W(ADDR_W)) u_regs (
    .clk(clk), .rst_n(rst_n),
    .bus_valid(bus_valid), .bus_write(bus_write), .bus_addr(bus_addr),
    .bus_be(bus_be), .bus_wdata(bus_wdata),
    .bus_ready(bus_ready), .bus_rdata(bus_rdata),
    .fire(fire), .pwr_idle(pwr_idle), .pwr_sleep(pwr_sleep),
    .ctrl(ctrl), .key_hit(key_hit), .stat(stat)
  );

  wdk_timebase #(.PRE_DIV(PRE_DIV)) u_time (
    .clk(clk), .rst_n(rst_n), .ctrl(ctrl), .key_hit(key_hit),
    .fire(fire), .rst_req(wdt_reset_req), .count(tb_count)
  );
endmodule

// File: rtl/wdk_checker.sv
module wdk_checker (
  input logic        clk,
  input logic        rst_n,
  input logic        bus_ready,
  input logic        rst_req,
  input logic        on,
  input logic [7:0]  stat,
  input logic [31:0] count
);
  // R4: the request never lasts longer than one cycle
  assert_pulse_single_R4: assert property (@(posedge clk) disable iff (!rst_n)
    rst_req |=> !rst_req);

  // R10: ready is low in the cycle after the enable falls
  assert_busy_after_off_R10: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(on) |-> !bus_ready);

  // R10: the busy cycle never stretches
  assert_busy_one_cycle_R10: assert property (@(posedge clk) disable iff (!rst_n)
    !bus_ready |=> bus_ready);

  // R7: a request only follows a cycle with the enable set
  assert_req_needs_on_R7: assert property (@(posedge clk) disable iff (!rst_n)
    rst_req |-> $past(on));

  // R7: the count is held at zero while disabled
  assert_count_held_R7: assert property (@(posedge clk) disable iff (!rst_n)
    !on |=> (count == 32'd0));

  // R8: every request is recorded in status bit 4
  assert_status_sticky_R8: assert property (@(posedge clk) disable iff (!rst_n)
    rst_req |-> stat[4]);
endmodule

bind wdog_keyclr wdk_checker u_chk (
  .clk(clk), .rst_n(rst_n), .bus_ready(bus_ready), .rst_req(wdt_reset_req),
  .on(ctrl_on), .stat(stat), .count(tb_count)
);

// File: tb/tb_wdog_keyclr.sv
module tb_wdog_keyclr;
  localparam int CLK_PERIOD = 10;
  localparam int WATCHDOG   = 20000;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        bus_valid = 1'b0, bus_write = 1'b0;
  logic        bus_ready;
  logic [4:0]  bus_addr = '0;
  logic [3:0]  bus_be = '0;
  logic [31:0] bus_wdata = '0, bus_rdata;
  logic        pwr_idle = 1'b0, pwr_sleep = 1'b0;
  logic        wdt_reset_req;

  int cyc = 0, pulses = 0, n_chk = 0, n_fail = 0;

  wdog_keyclr dut (
    .clk(clk), .rst_n(rst_n), .bus_valid(bus_valid), .bus_ready(bus_ready),
    .bus_write(bus_write), .bus_addr(bus_addr), .bus_be(bus_be),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .pwr_idle(pwr_idle),
    .pwr_sleep(pwr_sleep), .wdt_reset_req(wdt_reset_req)
  );

  always #(CLK_PERIOD/2) clk = ~clk;
  always @(posedge clk) begin
    cyc <= cyc + 1;
    if (wdt_reset_req) pulses <= pulses + 1;
  end

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [4:0] a, input logic [3:0] be, input logic [31:0] d,
                    output int edge_i);
    @(negedge clk);
    bus_valid = 1'b1; bus_write = 1'b1; bus_addr = a; bus_be = be; bus_wdata = d;
    while (!bus_ready) @(negedge clk);
    @(posedge clk);
    @(negedge clk);
    edge_i = cyc;
    bus_valid = 1'b0; bus_write = 1'b0;
  endtask

  task automatic rd(input logic [4:0] a, output logic [31:0] v);
    @(negedge clk);
    bus_valid = 1'b1; bus_write = 1'b0; bus_addr = a; bus_be = 4'hF;
    #1 v = bus_rdata;
    @(posedge clk);
    @(negedge clk);
    bus_valid = 1'b0;
  endtask

  task automatic wait_to(input int target);
    while (cyc < target) @(negedge clk);
  endtask

  task automatic expect_pulse(input string req, input int due);
    int p0;
    p0 = pulses;
    wait_to(due - 1);
    check({req, " no early pulse"}, pulses, p0);
    check({req, " low before due"}, 32'(wdt_reset_req), 32'd0);
    @(negedge clk);
    check({req, " high at due"}, 32'(wdt_reset_req), 32'd1);
    @(negedge clk);
    check({req, " one cycle wide"}, 32'(wdt_reset_req), 32'd0);
  endtask

  task automatic t_reset;
    logic [31:0] v;
    check("R1 ready", 32'(bus_ready), 32'd1);
    check("R1 request", 32'(wdt_reset_req), 32'd0);
    rd(5'h00, v); check("R1 control", v, 32'h0);
    rd(5'h10, v); check("R1 status", v, 32'h0);
  endtask

  task automatic t_fields;
    logic [31:0] v; int e;
    wr(5'h00, 4'b0011, 32'h0000_7FFF, e);
    rd(5'h00, v); check("R2 masked fields", v, 32'h0000_1FC1);
    wr(5'h00, 4'b0001, 32'h0000_0000, e);
    rd(5'h00, v); check("R2 lane strobe", v, 32'h0000_1F00);
    wr(5'h00, 4'b1111, 32'hABCD_00C0, e);
    rd(5'h00, v); check("R2 upper reads zero", v, 32'h0000_00C0);
  endtask

  task automatic t_alias;
    logic [31:0] v; int e;
    wr(5'h08, 4'b0011, 32'h0000_0301, e);
    rd(5'h00, v); check("R3 set alias", v, 32'h0000_03C1);
    wr(5'h04, 4'b0011, 32'h0000_00C1, e);
    rd(5'h00, v); check("R3 clear alias", v, 32'h0000_0300);
    wr(5'h04, 4'b0001, 32'h0000_0300, e);
    rd(5'h00, v); check("R3 clear honours lanes", v, 32'h0000_0300);
    wr(5'h04, 4'b0010, 32'h0000_0300, e);
    rd(5'h00, v); check("R3 clear upper lane", v, 32'h0000_0000);
  endtask

  task automatic t_expire;
    int e, d;
    wr(5'h00, 4'b0011, 32'h0000_8000, e);
    expect_pulse("R4 first expiry PS0", e + 32);
    expect_pulse("R4 repeat expiry PS0", e + 64);
    wr(5'h04, 4'b0010, 32'h0000_8000, d);
  endtask

  task automatic t_busy;
    logic [31:0] v; int e;
    wr(5'h00, 4'b0011, 32'h0000_8000, e);
    wr(5'h04, 4'b0010, 32'h0000_8000, e);
    check("R10 busy after off", 32'(bus_ready), 32'd0);
    bus_valid = 1'b1; bus_write = 1'b1; bus_addr = 5'h08; bus_be = 4'b0010;
    bus_wdata = 32'h0000_8000;
    @(negedge clk);
    bus_valid = 1'b0; bus_write = 1'b0;
    check("R10 busy lasts one cycle", 32'(bus_ready), 32'd1);
    rd(5'h00, v); check("R10 write in busy cycle dropped", v, 32'h0);
  endtask

  task automatic t_key;
    int e, k, p, d;
    wr(5'h00, 4'b0011, 32'h0000_8200, e);
    wait_to(e + 60);
    wr(5'h00, 4'b1100, 32'h5743_0000, k);
    expect_pulse("R5 key restarts count", k + 128);
    p = k + 128;
    wait_to(p + 40);
    wr(5'h00, 4'b1100, 32'h1234_0000, d);
    wr(5'h00, 4'b1111, 32'h5743_8200, d);
    wr(5'h00, 4'b0100, 32'h5743_0000, d);
    expect_pulse("R6 bad keys ignored", p + 128);
    wr(5'h04, 4'b0010, 32'h0000_8000, d);
  endtask

  task automatic t_window;
    logic [31:0] v; int e, k, k2, d;
    wr(5'h14, 4'b0001, 32'h0000_001C, d);
    wr(5'h00, 4'b0011, 32'h0000_8301, e);
    wait_to(e + 40);
    wr(5'h00, 4'b1100, 32'h5743_0000, k);
    check("R9 early key fires", 32'(wdt_reset_req), 32'd1);
    @(negedge clk);
    check("R9 early pulse one cycle", 32'(wdt_reset_req), 32'd0);
    rd(5'h10, v); check("R9 early key sets status", v, 32'h10);
    wait_to(k + 198);
    wr(5'h00, 4'b1100, 32'h5743_0000, k2);
    check("R9 open window no fire", 32'(wdt_reset_req), 32'd0);
    expect_pulse("R9 open window restarts", k2 + 256);
    wr(5'h04, 4'b0011, 32'h0000_8301, d);
  endtask

  task automatic t_off;
    int p0, d, e;
    wr(5'h00, 4'b0011, 32'h0000_0200, d);
    p0 = pulses;
    wr(5'h00, 4'b1100, 32'h5743_0000, d);
    wait_to(d + 300);
    check("R7 no request while off", pulses, p0);
    wr(5'h08, 4'b0010, 32'h0000_8000, e);
    expect_pulse("R7 full period after enable", e + 128);
    wr(5'h04, 4'b0010, 32'h0000_8000, d);
  endtask

  task automatic t_status;
    logic [31:0] v; int e, d;
    wr(5'h14, 4'b0001, 32'h0000_001C, d);
    wr(5'h00, 4'b0011, 32'h0000_0000, d);
    pwr_sleep = 1'b1;
    wr(5'h00, 4'b0011, 32'h0000_8000, e);
    expect_pulse("R8 sleep expiry", e + 32);
    wr(5'h04, 4'b0010, 32'h0000_8000, d);
    pwr_sleep = 1'b0;
    rd(5'h10, v); check("R8 sleep cause", v, 32'h18);
    wr(5'h10, 4'b0001, 32'h0000_0000, d);
    rd(5'h10, v); check("R8 direct write ignored", v, 32'h18);
    wr(5'h14, 4'b0001, 32'h0000_0010, d);
    rd(5'h10, v); check("R8 partial clear", v, 32'h08);
    wr(5'h14, 4'b0001, 32'h0000_001C, d);
    pwr_idle = 1'b1;
    wr(5'h00, 4'b0011, 32'h0000_8000, e);
    expect_pulse("R8 idle expiry", e + 32);
    wr(5'h04, 4'b0010, 32'h0000_8000, d);
    pwr_idle = 1'b0;
    rd(5'h10, v); check("R8 idle cause", v, 32'h14);
  endtask

  task automatic finish_run;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  endtask

  always @(posedge clk) begin
    if (cyc > WATCHDOG) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog: actual cycle %0d expected below %0d", cyc, WATCHDOG);
      finish_run();
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_fields();
    t_alias();
    t_expire();
    t_busy();
    t_key();
    t_window();
    t_off();
    t_status();
    finish_run();
  end
endmodule